// File: doc/BRIEF.md
# Critical-Word-First Refill Engine for Interleaved Memory

This block fetches one four-word cache block from a memory made of four interleaved banks. Word i of a block always lives in bank i. A miss arrives as a word address. The upper bits select the block, and the two low bits name the word the processor is stalled on, called the critical word. The engine spends one cycle putting the block address on the banks. All four banks then run their six-cycle access at the same time, and the shared return path carries one word per cycle. The whole block is therefore in place eleven cycles after the address cycle starts, against thirty-two for a single bank that serves the words one after another.

The critical word comes back first. Its arrival raises a one-cycle restart pulse so the processor can resume while the rest of the line is still filling. The other words follow in wraparound order. Every returned word carries its index within the block and a valid strobe, so the line buffer can write it into place. A done pulse marks the fourth word. No new miss is taken while a refill is in progress.

Top module: `cwf_refill`

## Requirements
- R1: After reset, req_ready is 1 and mem_rd_en, fill_valid, fill_restart and fill_done are all 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. In the next cycle (the address cycle), mem_rd_en is 1 for exactly that cycle, mem_line equals req_addr with its two low bits dropped, and req_ready is 0.
- R3: fill_valid is 0 during the address cycle and the six access cycles. It is 1 in the four cycles that follow, that is, in cycles 8 through 11 counted from the accepting edge.
- R4: For a request whose low two address bits are w, fill_idx in the four valid cycles is w, w+1, w+2 and w+3, each taken modulo 4.
- R5: In each valid cycle, fill_data equals the 32-bit lane fill_idx of mem_rdata (bits 32*fill_idx+31 down to 32*fill_idx). That lane holds bank fill_idx.
- R6: fill_restart is 1 only in the cycle carrying the critical word (the first valid cycle), and 0 in every other cycle.
- R7: fill_done is 1 only in the fourth valid cycle, eleven cycles after the address cycle began. fill_valid is 0 in the cycle after it.
- R8: While a refill is in progress, req_valid is ignored. No further mem_rd_en is issued, and the words, indices and data of the current refill are unchanged.
- R9: req_ready returns to 1 in the cycle after fill_done, so a new request can be accepted on that edge and refills can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | 32 | Word address of the missed word |
| mem_line | output | 30 | Block address presented to all banks |
| mem_rd_en | output | 1 | Address-cycle strobe to the banks |
| mem_rdata | input | 128 | Read data of the four banks, bank b in lane b |
| fill_valid | output | 1 | A block word is on fill_data |
| fill_idx | output | 2 | Index of that word within the block |
| fill_data | output | 32 | Returned word |
| fill_restart | output | 1 | Critical word present; processor may resume |
| fill_done | output | 1 | Last word of the block present |

## Verification
The refill is run once for each of the four critical-word positions. This separates a correct wraparound from orders that always start at word 0 or that count downward, and it catches a restart or done pulse tied to a fixed index instead of to the first and last slot. A cycle-exact sweep over each refill confirms the eleven-cycle shape, so an access count off by one in either direction is exposed. A back-to-back pair tests whether the engine becomes ready right after the last word. A refill with a conflicting request held on the input shows whether a busy engine wrongly re-latches the address or reissues the bank strobe.

// File: rtl/cwf_refill_pkg.sv
package cwf_refill_pkg;

  typedef enum logic {
    RF_IDLE = 1'b0,
    RF_BUSY = 1'b1
  } rf_state_e;

endpackage

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl
  import cwf_refill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 2,
  localparam int LINE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              last_word,
  output logic              req_ready,
  output logic              accept,
  output logic [OFS_W-1:0]  crit_q,
  output logic [LINE_W-1:0] line_q,
  output logic              rd_en_q
);

  rf_state_e state_q, state_d;

  assign req_ready = (state_q == RF_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RF_IDLE: if (accept)    state_d = RF_BUSY;
      RF_BUSY: if (last_word) state_d = RF_IDLE;
      default:                state_d = RF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RF_IDLE;
      rd_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_en_q <= accept;
    end
  end

  // request fields captured only on the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q <= '0;
      line_q <= '0;
    end else if (accept) begin
      crit_q <= req_addr[OFS_W-1:0];
      line_q <= req_addr[ADDR_W-1:OFS_W];
    end
  end

endmodule

// File: rtl/cwf_bank_timer.sv
module cwf_bank_timer #(
  parameter int BANK_ID  = 0,
  parameter int NBANK    = 4,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 6,
  localparam int OFS_W   = $clog2(NBANK),
  localparam int CNT_W   = $clog2(ADDR_CYC + ACC_CYC + NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFS_W-1:0] crit,
  output logic             fire
);

  logic [OFS_W-1:0] slot;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  // transfer slot of this bank relative to the critical word
  assign slot = OFS_W'(BANK_ID) - crit;
  assign fire = armed_q && (cnt_q == '0);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (start) begin
      cnt_d   = CNT_W'(ADDR_CYC + ACC_CYC) + CNT_W'(slot);
      armed_d = 1'b1;
    end else if (fire) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/cwf_word_mux.sv
module cwf_word_mux #(
  parameter int NBANK  = 4,
  parameter int DATA_W = 32,
  localparam int OFS_W = $clog2(NBANK)
) (
  input  logic [NBANK-1:0]        fire,
  input  logic [NBANK*DATA_W-1:0] rdata,
  input  logic [OFS_W-1:0]        crit,
  output logic                    valid,
  output logic [OFS_W-1:0]        idx,
  output logic [DATA_W-1:0]       data,
  output logic                    first,
  output logic                    last
);

  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(NBANK - 1);

  always_comb begin
    idx  = '0;
    data = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (fire[b]) begin
        idx  = idx  | OFS_W'(b);
        data = data | rdata[b*DATA_W +: DATA_W];
      end
    end
  end

  assign valid = |fire;
  assign first = valid && (idx == crit);
  assign last  = valid && (idx == OFS_W'(crit + LAST_OFS));

endmodule

// File: rtl/cwf_refill.sv
module cwf_refill #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NBANK    = 4,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 6,
  localparam int OFS_W   = $clog2(NBANK),
  localparam int LINE_W  = ADDR_W - OFS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic [LINE_W-1:0]       mem_line,
  output logic                    mem_rd_en,
  input  logic [NBANK*DATA_W-1:0] mem_rdata,
  output logic                    fill_valid,
  output logic [OFS_W-1:0]        fill_idx,
  output logic [DATA_W-1:0]       fill_data,
  output logic                    fill_restart,
  output logic                    fill_done
);

  logic             accept;
  logic [OFS_W-1:0] crit_q;
  logic [NBANK-1:0] fire;

  cwf_refill_ctrl #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .last_word (fill_done),
    .req_ready (req_ready),
    .accept    (accept),
    .crit_q    (crit_q),
    .line_q    (mem_line),
    .rd_en_q   (mem_rd_en)
  );

  // start is taken from the raw request: timers load on the accepting edge
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cwf_bank_timer #(
      .BANK_ID  (b),
      .NBANK    (NBANK),
      .ADDR_CYC (ADDR_CYC),
      .ACC_CYC  (ACC_CYC)
    ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .crit  (req_addr[OFS_W-1:0]),
      .fire  (fire[b])
    );
  end

  cwf_word_mux #(
    .NBANK  (NBANK),
    .DATA_W (DATA_W)
  ) u_mux (
    .fire  (fire),
    .rdata (mem_rdata),
    .crit  (crit_q),
    .valid (fill_valid),
    .idx   (fill_idx),
    .data  (fill_data),
    .first (fill_restart),
    .last  (fill_done)
  );

endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
  parameter int OFS_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_rd_en,
  input logic             fill_valid,
  input logic [OFS_W-1:0] fill_idx,
  input logic             fill_restart,
  input logic             fill_done
);

  a_r2_strobe_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd_en && !req_ready));

  a_r8_strobe_only_once: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  a_r3_no_word_in_addr_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !fill_valid);

  a_r4_index_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_done) |=> (fill_valid && fill_idx == OFS_W'($past(fill_idx) + 1'b1)));

  a_r6_restart_carries_word: assert property (@(posedge clk) disable iff (!rst_n)
    fill_restart |-> (fill_valid && !req_ready));

  a_r7_done_ends_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_valid);

  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> req_ready);

endmodule

bind cwf_refill cwf_refill_chk #(.OFS_W(OFS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_rd_en    (mem_rd_en),
  .fill_valid   (fill_valid),
  .fill_idx     (fill_idx),
  .fill_restart (fill_restart),
  .fill_done    (fill_done)
);

// File: tb/cwf_refill_bench.sv
module cwf_refill_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [31:0]  req_addr;
  logic [29:0]  mem_line;
  logic         mem_rd_en;
  logic [127:0] mem_rdata;
  logic         fill_valid;
  logic [1:0]   fill_idx;
  logic [31:0]  fill_data;
  logic         fill_restart;
  logic         fill_done;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cwf_refill u_cwf_refill (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .mem_line     (mem_line),
    .mem_rd_en    (mem_rd_en),
    .mem_rdata    (mem_rdata),
    .fill_valid   (fill_valid),
    .fill_idx     (fill_idx),
    .fill_data    (fill_data),
    .fill_restart (fill_restart),
    .fill_done    (fill_done)
  );

  // bank model: latches the block address on the strobe, lane b holds bank b
  logic [29:0] bank_line = '0;
  always_ff @(posedge clk) if (mem_rd_en) bank_line <= mem_line;
  always_comb begin
    for (int b = 0; b < 4; b++)
      mem_rdata[b*32 +: 32] = {bank_line, 2'(b)} ^ 32'h5A5A_0000;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one refill, checked cycle by cycle; returns at the negedge of cycle 12
  task automatic run_refill(input logic [31:0] addr, input bit disturb);
    logic [29:0] line = addr[31:2];
    logic [1:0]  crit = addr[1:0];
    chk(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr  = addr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_rd_en == 1'b1, "R2 address strobe", 32'(mem_rd_en), 32'd1);
    chk(mem_line == line, "R2 block address", 32'(mem_line), 32'(line));
    chk(req_ready == 1'b0, "R2 busy after accept", 32'(req_ready), 32'd0);
    chk(fill_valid == 1'b0, "R3 no word in address cycle", 32'(fill_valid), 32'd0);
    for (int c = 2; c <= 11; c++) begin
      if (disturb && c == 3) begin
        req_valid = 1'b1;
        req_addr  = addr ^ 32'h0000_F0F1;
      end
      if (disturb && c == 10) req_valid = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b0, "R8 busy during refill", 32'(req_ready), 32'd0);
      chk(mem_rd_en == 1'b0, "R8 single strobe", 32'(mem_rd_en), 32'd0);
      if (c < 8) begin
        chk(fill_valid == 1'b0, "R3 quiet during access", 32'(fill_valid), 32'd0);
        chk(fill_restart == 1'b0, "R6 no early restart", 32'(fill_restart), 32'd0);
      end else begin
        logic [1:0]  k    = 2'(c - 8);
        logic [1:0]  eidx = crit + k;
        logic [31:0] edat = {line, eidx} ^ 32'h5A5A_0000;
        chk(fill_valid == 1'b1, "R3 word slot", 32'(fill_valid), 32'd1);
        chk(fill_idx == eidx, "R4 wraparound index", 32'(fill_idx), 32'(eidx));
        chk(fill_data == edat, "R5 word data", fill_data, edat);
        chk(fill_restart == (k == 2'd0), "R6 restart on critical word",
            32'(fill_restart), 32'(k == 2'd0));
        chk(fill_done == (k == 2'd3), "R7 done on last word",
            32'(fill_done), 32'(k == 2'd3));
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after done", 32'(req_ready), 32'd1);
    chk(fill_valid == 1'b0, "R7 no word after done", 32'(fill_valid), 32'd0);
    chk(fill_done == 1'b0, "R7 done is one cycle", 32'(fill_done), 32'd0);
  endtask

  task automatic test_reset();
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(mem_rd_en == 1'b0, "R1 no strobe", 32'(mem_rd_en), 32'd0);
    chk(fill_valid == 1'b0, "R1 no word", 32'(fill_valid), 32'd0);
    chk(fill_restart == 1'b0, "R1 no restart", 32'(fill_restart), 32'd0);
    chk(fill_done == 1'b0, "R1 no done", 32'(fill_done), 32'd0);
  endtask

  task automatic test_all_offsets();
    run_refill(32'h0000_1000, 1'b0);
    run_refill(32'h0001_2345, 1'b0);
    run_refill(32'hDEAD_BEE6, 1'b0);
    run_refill(32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic test_back_to_back();
    run_refill(32'h0000_0042, 1'b0);
    run_refill(32'h0000_0043, 1'b0);
  endtask

  task automatic test_ignore_busy();
    run_refill(32'hCAFE_0019, 1'b1);
    @(negedge clk);
    chk(mem_rd_en == 1'b0, "R8 no late accept", 32'(mem_rd_en), 32'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_all_offsets();
    test_back_to_back();
    test_ignore_busy();
    run_refill(32'h0000_0002, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", n_chk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule